// File: doc/BRIEF.md
# Serial Flash Execute-in-Place Mode Tracker

This block sits on the memory side of a multi-lane serial flash. It follows each transaction framed by the active-low chip select, splits it into command, address, dummy and data phases, and keeps one flag saying whether execute-in-place (continuous read) is active. While that flag is set, a new transaction has no command bits and begins directly with the address. The flag is decided by a single confirmation bit taken from lane 0 on the first dummy clock of each transaction.

The block runs on a fast core clock and oversamples the serial clock, chip select and data lanes, which arrive already synchronised. The lane width (1, 2 or 4 lanes) sets how many serial clocks the command and address phases take. A dedicated active-low reset pin clears the mode. In the 4-lane protocol it acts only while the device is deselected. The read path, the memory array and the configuration registers sit elsewhere. Every transaction is framed as a fast read, and the opcode content is not decoded here.

Top module: `xip_mode_tracker`

## Requirements
- R1: After the chip reset `rst_n` is released, `xip_active` is 0 and `phase` is 0 (idle).
- R2: When `xip_active` is 0, a falling edge of `cs_n` starts the command phase (`phase` = 1). It lasts 8/lanes serial clock rising edges and then moves to the address phase (`phase` = 2). `io_mode` 0 = 1 lane, 1 = 2 lanes, 2 = 4 lanes, and 3 is treated as 1 lane.
- R3: The address phase lasts 24/lanes rising edges (24, 12 or 6). The dummy phase (`phase` = 3) follows for DUMMY_CYCLES (default 8) rising edges. The data phase (`phase` = 4) then holds until deselect.
- R4: The confirmation bit is `dq[0]` on the first rising edge of the dummy phase. If it is 0 and either `xip_req` is 1 or the mode is already active, `xip_active` is 1 after `cs_n` rises. If it is 0 while `xip_req` is 0 and the mode is inactive, `xip_active` stays 0. Later dummy edges do not affect it.
- R5: When `xip_active` is 1, a falling edge of `cs_n` enters the address phase (`phase` = 2) directly, with no command clocks.
- R6: A confirmation bit of 1 clears `xip_active` when `cs_n` rises, and the next transaction starts with the command phase.
- R7: On the first dummy edge, `dq[1]` (2-lane mode) and `dq[3:1]` (4-lane mode) have no effect on the outcome.
- R8: A transaction deselected before its first dummy edge leaves `xip_active` unchanged.
- R9: `xip_active` changes only on the core clock edge that sees `cs_n` rise, or when the reset pin acts. It does not change while still selected after the bit is captured.
- R10: In 1-lane and 2-lane modes, `rst_pin_n` low clears `xip_active` on the next clock edge and returns `phase` to idle. The phase stays idle until the next `cs_n` falling edge.
- R11: In 4-lane mode, `rst_pin_n` low while `cs_n` is low has no effect on `xip_active` or on phase progress. While `cs_n` is high it clears `xip_active`.
- R12: `phase` is 0 (idle) on the clock after any cycle in which `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial interface |
| rst_n | input | 1 | Asynchronous active-low chip reset, released synchronously inside |
| cs_n | input | 1 | Sampled active-low chip select |
| sck | input | 1 | Sampled serial clock level |
| dq | input | 4 | Sampled data lane values |
| io_mode | input | 2 | Lane width: 0 single, 1 dual, 2 quad |
| xip_req | input | 1 | Request that a confirmation bit of 0 enables execute-in-place |
| rst_pin_n | input | 1 | Active-low device reset pin |
| xip_active | output | 1 | Execute-in-place mode is active |
| phase | output | 3 | Current phase: 0 idle, 1 command, 2 address, 3 dummy, 4 data |

## Verification
The hardest state to reach is a 4-lane transaction already in execute-in-place that gets a reset pin pulse while still selected. Reaching it takes one full entry transaction with a 0 confirmation bit, and then a second selection that stops in the address phase. The stimulus builds that history first with a complete entry sequence. It then pulses the pin mid-address and lets the transaction run on. The flag must survive, and the dummy phase must come after the normal count. The abort and exit cases reuse the same entry sequence so that they start from an active mode.

// File: rtl/xip_pkg.sv
package xip_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    IO_SINGLE = 2'd0,
    IO_DUAL   = 2'd1,
    IO_QUAD   = 2'd2
  } io_mode_e;

  // log2 of the active lane count; code 3 falls back to a single lane
  function automatic logic [1:0] lane_shift(input logic [1:0] mode);
    case (mode)
      IO_DUAL: lane_shift = 2'd1;
      IO_QUAD: lane_shift = 2'd2;
      default: lane_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/xip_rst_sync.sv
module xip_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_out = hold_q;
endmodule

// File: rtl/xip_edge_detect.sv
module xip_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic cs_fall,
  output logic cs_rise
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q;
  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = ~cs_q & cs_n;
endmodule

// File: rtl/xip_phase_seq.sv
module xip_phase_seq
  import xip_pkg::*;
#(
  parameter int unsigned CMD_BITS     = 8,
  parameter int unsigned ADDR_BITS    = 24,
  parameter int unsigned DUMMY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cs_fall,
  input  logic       sck_rise,
  input  logic [1:0] lane_sh,
  input  logic       xip_active,
  input  logic       abort,
  output phase_e     phase,
  output logic       first_dummy
);
  localparam int unsigned MAX_A   = (CMD_BITS > ADDR_BITS) ? CMD_BITS : ADDR_BITS;
  localparam int unsigned MAX_LEN = (MAX_A > DUMMY_CYCLES) ? MAX_A : DUMMY_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CYCLES - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmd_last, addr_last;
  logic             step;

  assign cmd_last  = CNT_W'((CMD_BITS >> lane_sh) - 1);
  assign addr_last = CNT_W'((ADDR_BITS >> lane_sh) - 1);
  assign step      = sck_rise & ~cs_n & ~abort;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (cs_n || abort) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (cs_fall) begin
      phase_d = xip_active ? PH_ADDR : PH_CMD;
      cnt_d   = '0;
    end else if (step) begin
      case (phase_q)
        PH_CMD: begin
          if (cnt_q == cmd_last) begin
            phase_d = PH_ADDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt_q == addr_last) begin
            phase_d = PH_DUMMY;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt_q == DUMMY_LAST) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          phase_d = phase_q;
          cnt_d   = cnt_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase       = phase_q;
  assign first_dummy = step && (phase_q == PH_DUMMY) && (cnt_q == '0);

  assert_idle_deselect_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> phase_q == PH_IDLE);

  assert_xip_skips_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && xip_active && !abort) |=> phase_q == PH_ADDR);

  assert_cmd_when_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !xip_active && !abort) |=> phase_q == PH_CMD);

  assert_addr_to_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase_q == PH_ADDR && cnt_q == addr_last) |=> phase_q == PH_DUMMY);
endmodule

// File: rtl/xip_state.sv
module xip_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       first_dummy,
  input  logic [3:0] dq,
  input  logic       quad,
  input  logic       xip_req,
  input  logic       rst_pin_n,
  output logic       xip_active,
  output logic       abort
);
  logic xip_q, xip_d;
  logic conf_q, conf_d;
  logic capt_q, capt_d;
  logic lanes_unused;

  // only lane 0 carries the confirmation bit; the upper lanes are don't-care
  assign lanes_unused = ^dq[3:1];

  // in quad mode the pin only acts while deselected
  assign abort = ~rst_pin_n & (~quad | cs_n);

  always_comb begin
    xip_d  = xip_q;
    conf_d = conf_q;
    capt_d = capt_q;
    if (abort) begin
      xip_d  = 1'b0;
      capt_d = 1'b0;
    end else begin
      if (cs_fall) begin
        capt_d = 1'b0;
      end
      if (first_dummy) begin
        capt_d = 1'b1;
        conf_d = dq[0];
      end
      if (cs_rise && capt_q) begin
        xip_d = (xip_q | xip_req) & ~conf_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xip_q  <= 1'b0;
      conf_q <= 1'b0;
      capt_q <= 1'b0;
    end else begin
      xip_q  <= xip_d;
      conf_q <= conf_d;
      capt_q <= capt_d;
    end
  end

  assign xip_active = xip_q;

  assert_change_at_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && !abort) |=> $stable(xip_q));

  assert_pin_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin_n && !quad) |=> !xip_q);

  assert_quad_pin_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (quad && !cs_n) |=> $stable(xip_q));

  assert_confirm_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && capt_q && conf_q) |=> !xip_q);
endmodule

// File: rtl/xip_mode_tracker.sv
module xip_mode_tracker
  import xip_pkg::*;
#(
  parameter int unsigned CMD_BITS     = 8,
  parameter int unsigned ADDR_BITS    = 24,
  parameter int unsigned DUMMY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] dq,
  input  logic [1:0] io_mode,
  input  logic       xip_req,
  input  logic       rst_pin_n,
  output logic       xip_active,
  output logic [2:0] phase
);
  logic   rst_n_sync;
  logic   sck_rise, cs_fall, cs_rise;
  logic   first_dummy, abort, quad;
  logic [1:0] lane_sh;
  phase_e phase_cur;

  assign quad    = (io_mode == IO_QUAD);
  assign lane_sh = lane_shift(io_mode);

  xip_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  xip_edge_detect u_edges (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .sck      (sck),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise)
  );

  xip_phase_seq #(
    .CMD_BITS     (CMD_BITS),
    .ADDR_BITS    (ADDR_BITS),
    .DUMMY_CYCLES (DUMMY_CYCLES)
  ) u_phase (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cs_n        (cs_n),
    .cs_fall     (cs_fall),
    .sck_rise    (sck_rise),
    .lane_sh     (lane_sh),
    .xip_active  (xip_active),
    .abort       (abort),
    .phase       (phase_cur),
    .first_dummy (first_dummy)
  );

  xip_state u_state (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cs_n        (cs_n),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .first_dummy (first_dummy),
    .dq          (dq),
    .quad        (quad),
    .xip_req     (xip_req),
    .rst_pin_n   (rst_pin_n),
    .xip_active  (xip_active),
    .abort       (abort)
  );

  assign phase = phase_cur;
endmodule

// File: tb/test_xip_mode_tracker.sv
module test_xip_mode_tracker;
  localparam int DUMMY = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic       sck;
  logic [3:0] dq;
  logic [1:0] io_mode;
  logic       xip_req;
  logic       rst_pin_n;
  logic       xip_active;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xip_mode_tracker #(.DUMMY_CYCLES(DUMMY)) i_xip_mode_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .dq         (dq),
    .io_mode    (io_mode),
    .xip_req    (xip_req),
    .rst_pin_n  (rst_pin_n),
    .xip_active (xip_active),
    .phase      (phase)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int cmd_len(logic [1:0] m);
    return (m == 2'd1) ? 4 : (m == 2'd2) ? 2 : 8;
  endfunction

  function automatic int addr_len(logic [1:0] m);
    return (m == 2'd1) ? 12 : (m == 2'd2) ? 6 : 24;
  endfunction

  task automatic pulses(int n, logic [3:0] v);
    for (int i = 0; i < n; i++) begin
      dq  = v;
      sck = 1'b0;
      nclk(2);
      sck = 1'b1;
      nclk(2);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    nclk(2);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    sck  = 1'b0;
    nclk(2);
  endtask

  // R1, R12: state right after reset
  task automatic t_reset();
    check("R1 xip after reset", xip_active, 0);
    check("R1 phase after reset", phase, 0);
    nclk(3);
    check("R12 idle while deselected", phase, 0);
  endtask

  // full normal transaction ending with confirmation 0 and xip_req set
  task automatic t_enter(logic [1:0] m);
    io_mode = m;
    xip_req = 1'b1;
    sel();
    check("R2 command phase at start", phase, 1);
    pulses(cmd_len(m) - 1, 4'h0);
    check("R2 command phase before last bit", phase, 1);
    pulses(1, 4'h0);
    check("R2 address after command", phase, 2);
    pulses(addr_len(m) - 1, 4'h0);
    check("R3 address before last edge", phase, 2);
    pulses(1, 4'h0);
    check("R3 dummy after address", phase, 3);
    pulses(1, 4'b1110);   // R7: upper lanes high, lane 0 low
    check("R9 xip unchanged after capture", xip_active, 0);
    pulses(DUMMY - 1, 4'hF);
    check("R3 data after dummy", phase, 4);
    pulses(3, 4'hF);
    check("R9 xip unchanged while selected", xip_active, 0);
    desel();
    check("R4 xip entered on deselect", xip_active, 1);
    check("R12 idle after deselect", phase, 0);
  endtask

  // transaction while xip is active; dqv is driven on the first dummy edge
  task automatic t_xip_read(logic [1:0] m, logic [3:0] dqv, int exp_after, string tag);
    io_mode = m;
    sel();
    check("R5 xip transaction starts at address", phase, 2);
    pulses(addr_len(m), 4'h0);
    check("R5 dummy after address", phase, 3);
    pulses(1, dqv);
    pulses(DUMMY + 1, 4'h0);
    check("R9 xip held while selected", xip_active, 1);
    desel();
    check(tag, xip_active, exp_after);
  endtask

  task automatic t_exit(logic [1:0] m);
    t_xip_read(m, 4'b0001, 0, "R6 confirmation 1 exits xip");
    sel();
    check("R6 command phase after exit", phase, 1);
    desel();
  endtask

  task automatic t_abort(logic [1:0] m);
    io_mode = m;
    sel();
    pulses(addr_len(m) - 1, 4'hF);
    desel();
    check("R8 abort keeps xip active", xip_active, 1);
  endtask

  task automatic t_no_req();
    io_mode = 2'd0;
    xip_req = 1'b0;
    sel();
    pulses(cmd_len(2'd0) + addr_len(2'd0), 4'h0);
    pulses(DUMMY + 2, 4'h0);
    desel();
    check("R4 no entry without request", xip_active, 0);
    // aborted normal transaction with request set stays out
    xip_req = 1'b1;
    sel();
    pulses(5, 4'h0);
    desel();
    check("R8 abort keeps xip inactive", xip_active, 0);
  endtask

  task automatic t_pin_narrow(logic [1:0] m);
    t_enter(m);
    sel();
    pulses(2, 4'h0);
    rst_pin_n = 1'b0;
    nclk(1);
    check("R10 pin clears xip", xip_active, 0);
    check("R10 pin forces idle", phase, 0);
    rst_pin_n = 1'b1;
    pulses(2, 4'h0);
    check("R10 stays idle until next select", phase, 0);
    desel();
  endtask

  task automatic t_pin_quad();
    t_enter(2'd2);
    sel();
    check("R5 quad xip starts at address", phase, 2);
    pulses(2, 4'h0);
    rst_pin_n = 1'b0;
    nclk(4);
    check("R11 pin ignored while selected xip", xip_active, 1);
    check("R11 pin ignored while selected phase", phase, 2);
    rst_pin_n = 1'b1;
    pulses(addr_len(2'd2) - 2, 4'h0);
    check("R11 address count unaffected", phase, 3);
    pulses(DUMMY, 4'h0);
    desel();
    check("R11 xip kept after masked pulse", xip_active, 1);
    rst_pin_n = 1'b0;
    nclk(1);
    check("R11 pin clears when deselected", xip_active, 0);
    rst_pin_n = 1'b1;
    nclk(2);
  endtask

  initial begin
    rst_n     = 1'b0;
    cs_n      = 1'b1;
    sck       = 1'b0;
    dq        = 4'h0;
    io_mode   = 2'd0;
    xip_req   = 1'b0;
    rst_pin_n = 1'b1;
    nclk(3);
    rst_n = 1'b1;
    nclk(3);

    t_reset();
    t_no_req();
    t_enter(2'd0);
    t_xip_read(2'd0, 4'b0000, 1, "R4 confirmation 0 keeps xip");
    t_abort(2'd0);
    t_exit(2'd0);
    t_enter(2'd1);
    t_xip_read(2'd1, 4'b0010, 1, "R7 dual lane 1 ignored");
    t_exit(2'd1);
    t_enter(2'd2);
    t_xip_read(2'd2, 4'b1110, 1, "R7 quad lanes 3..1 ignored");
    t_abort(2'd2);
    t_exit(2'd2);
    t_pin_narrow(2'd0);
    t_pin_narrow(2'd1);
    t_pin_quad();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule